// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Sequencer

This block sits between a synchronous on-chip requester and an external asynchronous static RAM of 64K words by 16 bits. The RAM has active-low chip, output and write enables and one active-low enable per byte lane. Each user request is a single read or write. It carries a word address, write data and a per-lane byte mask. The sequencer turns it into a read or write cycle on the memory pins. Every phase of that cycle lasts a number of clocks set by a parameter. Each count is the nanosecond limit of the RAM divided by the clock period and rounded up. At the 5 ns default clock the limits become a 3-cycle read window, a 2-cycle write strobe and 1 turnaround cycle.

The request side is a valid/ready stream. `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold its request, unchanged, until that edge. The response side has no back-pressure. `rsp_valid` is a one-cycle done pulse, and a read result is carried on `rsp_rdata` in that cycle.

The data bus is split into an input, an output and an output enable, so a pad ring can join them. The sequencer drives the bus only in write phases, and only after the RAM's outputs have been disabled for a full clock.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held and after it is released, `mem_ce_n`, `mem_oe_n`, `mem_we_n` and both `mem_lane_n` bits are 1, `mem_dq_oe` and `rsp_valid` are 0, and `req_ready` is 1.
- R2: An accepted read with a nonzero mask drives `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly RD_WAIT cycles, starting in the cycle after the accepting edge. All strobes return high in the next cycle.
- R3: The sequencer samples read data on the edge that ends the read window. In the following cycle it pulses `rsp_valid` for one cycle, with `rsp_rdata` holding the sampled byte of each enabled lane and zero in each disabled lane.
- R4: An accepted write with a nonzero mask starts with TURNAROUND cycles in which `mem_ce_n`=0, `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0. WE_LOW cycles follow in which `mem_we_n`=0 and `mem_dq_oe`=1, with `mem_dq_o` equal to the write data.
- R5: After the strobe phase comes one cycle in which `mem_we_n` and `mem_ce_n` are 1, both lanes are disabled, and the write data is still driven. `rsp_valid` pulses in the cycle after that.
- R6: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. `mem_dq_oe` rises only after a cycle in which `mem_oe_n` was 1, and `mem_we_n` is 0 only while `mem_ce_n` is 0 and at least one lane is enabled.
- R7: A request with mask 2'b00 produces `rsp_valid` in the next cycle with `rsp_rdata`=0, makes no memory access, and changes no stored word.
- R8: `req_ready` is 0 from the accepting edge until `rsp_valid` is raised. A request that is held while the sequencer is busy is taken at the first edge where `req_ready` is 1.
- R9: `mem_addr` equals the accepted request address whenever `mem_ce_n` is 0, and it stays stable while `mem_ce_n` stays 0.
- R10: Mask bit 0 controls `mem_lane_n[0]` and data bits 7:0, and mask bit 1 controls `mem_lane_n[1]` and bits 15:8. A lane's enable is 0 during the active phases of a cycle exactly when its mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte-lane mask, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 16 | RAM address |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_lane_n | output | 2 | RAM byte-lane enables, active low |
| mem_dq_o | output | 16 | Data toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data from the RAM |

## Verification
A wrong phase counter makes a strobe too short or too long. This shows on the strobe pins in the first cycle where the expected phase boundary passes. A wrong state shows at once as a strobe combination that no cycle of either type contains, for example output and write enable low together. A lane-mask fault shows either on `mem_lane_n` during the access or as a wrong byte in `rsp_rdata` on the done pulse. A write fault stays hidden at the pins until a later read of that address returns the wrong byte.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WTURN,
    ST_WSTROBE,
    ST_WEND
  } seq_state_t;
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_mux.sv
module sram_lane_mux #(
  parameter int LANES = 2
) (
  input  logic [LANES*8-1:0] din,
  input  logic [LANES-1:0]   mask,
  output logic [LANES*8-1:0] dout
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign dout[l*8 +: 8] = mask[l] ? din[l*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int RD_WAIT    = 3,
  parameter int WE_LOW     = 2,
  parameter int TURNAROUND = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [DATA_W/8-1:0]  req_mask,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic                 mem_ce_n,
  output logic                 mem_oe_n,
  output logic                 mem_we_n,
  output logic [DATA_W/8-1:0]  mem_lane_n,
  output logic [DATA_W-1:0]    mem_dq_o,
  output logic                 mem_dq_oe,
  input  logic [DATA_W-1:0]    mem_dq_i
);
  localparam int LANES = DATA_W / 8;
  localparam int MAXP  = (RD_WAIT > WE_LOW)
                         ? ((RD_WAIT > TURNAROUND) ? RD_WAIT : TURNAROUND)
                         : ((WE_LOW > TURNAROUND) ? WE_LOW : TURNAROUND);
  localparam int CW    = $clog2(MAXP + 1);

  seq_state_t          state_q, nxt;
  logic                accept, zero_req, expired, load;
  logic [CW-1:0]       load_val;
  logic [LANES-1:0]    mask_q, mask_d;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q, lane_data;
  logic                active_nxt;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign zero_req  = accept && (req_mask == '0);
  assign mask_d    = accept ? req_mask : mask_q;

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept && !zero_req) nxt = req_write ? ST_WTURN : ST_READ;
      ST_READ:    if (expired) nxt = ST_IDLE;
      ST_WTURN:   if (expired) nxt = ST_WSTROBE;
      ST_WSTROBE: if (expired) nxt = ST_WEND;
      ST_WEND:    nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    load     = (nxt != state_q);
    load_val = '0;
    unique case (nxt)
      ST_READ:    load_val = CW'(RD_WAIT - 1);
      ST_WTURN:   load_val = CW'(TURNAROUND - 1);
      ST_WSTROBE: load_val = CW'(WE_LOW - 1);
      default:    load = 1'b0;
    endcase
  end

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  sram_lane_mux #(.LANES(LANES)) u_mux (
    .din  (mem_dq_i),
    .mask (mask_q),
    .dout (lane_data)
  );

  assign active_nxt = (nxt == ST_READ) || (nxt == ST_WTURN) || (nxt == ST_WSTROBE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      mask_q     <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      mem_ce_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_lane_n <= '1;
      mem_dq_oe  <= 1'b0;
    end else begin
      state_q <= nxt;
      if (accept) begin
        mask_q  <= req_mask;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      rsp_valid <= zero_req || (state_q == ST_WEND) ||
                   ((state_q == ST_READ) && expired);
      if (zero_req)                            rsp_rdata <= '0;
      else if ((state_q == ST_READ) && expired) rsp_rdata <= lane_data;
      mem_ce_n   <= !active_nxt;
      mem_oe_n   <= (nxt != ST_READ);
      mem_we_n   <= (nxt != ST_WSTROBE);
      mem_lane_n <= active_nxt ? ~mask_d : '1;
      mem_dq_oe  <= (nxt == ST_WSTROBE) || (nxt == ST_WEND);
    end
  end

  assign mem_addr = addr_q;
  assign mem_dq_o = wdata_q;
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int LANES  = 2,
  parameter int WE_LOW = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [LANES-1:0]  mem_lane_n,
  input logic              mem_dq_oe
);
  logic [15:0] we_run;

  always_ff @(posedge clk) begin
    if (!rst_n)         we_run <= '0;
    else if (!mem_we_n) we_run <= we_run + 1'b1;
    else                we_run <= '0;
  end

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R6
  AST_DRIVE_AFTER_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(mem_oe_n)); // R6
  AST_WRITE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && (mem_lane_n != '1))); // R6
  AST_NO_OE_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n)); // R2
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run >= 16'(WE_LOW))); // R4
  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready); // R8
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R9
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .LANES  (DATA_W/8),
  .WE_LOW (WE_LOW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_lane_n (mem_lane_n),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sim_sram_lane_ctrl.sv
module sim_sram_lane_ctrl;
  localparam int RDW = 3;
  localparam int WEL = 2;
  localparam int TA  = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_o, mem_dq_i;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_lane_n;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sram_lane_ctrl #(.RD_WAIT(RDW), .WE_LOW(WEL), .TURNAROUND(TA)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_lane_n(mem_lane_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // pin-level model of the asynchronous RAM
  logic [15:0] ram [int];
  logic [15:0] st_addr, st_data;
  logic [1:0]  st_lane_n;
  bit          st_pend = 0;

  function automatic logic [15:0] ram_rd(input logic [15:0] a);
    return ram.exists(int'(a)) ? ram[int'(a)] : 16'h0000;
  endfunction

  always_comb begin
    logic rd_en;
    logic [15:0] w;
    rd_en = !mem_ce_n && !mem_oe_n && mem_we_n;
    w = ram_rd(mem_addr);
    mem_dq_i[7:0]  = (rd_en && !mem_lane_n[0]) ? w[7:0]  : 8'hEE;
    mem_dq_i[15:8] = (rd_en && !mem_lane_n[1]) ? w[15:8] : 8'hEE;
  end

  always @(negedge clk) begin
    if (!mem_we_n && !mem_ce_n) begin
      st_addr = mem_addr;
      st_data = mem_dq_oe ? mem_dq_o : 16'hDEAD;
      st_lane_n = mem_lane_n;
      st_pend = 1;
    end else if (st_pend) begin
      logic [15:0] w;
      w = ram_rd(st_addr);
      if (!st_lane_n[0]) w[7:0]  = st_data[7:0];
      if (!st_lane_n[1]) w[15:8] = st_data[15:8];
      ram[int'(st_addr)] = w;
      st_pend = 0;
    end
  end

  // reference model: expected pin values per cycle
  typedef struct {
    logic        ce_n, oe_n, we_n, dq_oe, rsp, rdy, chk_rd, chk_dq;
    logic [1:0]  lane_n;
    logic [15:0] addr, dq, rdata;
    int          tag;
  } exp_t;

  exp_t q[$];
  logic [15:0] shadow [int];

  function automatic exp_t idle_e();
    exp_t e;
    e.ce_n = 1; e.oe_n = 1; e.we_n = 1; e.dq_oe = 0; e.rsp = 0; e.rdy = 1;
    e.chk_rd = 0; e.chk_dq = 0; e.lane_n = 2'b11; e.addr = '0; e.dq = '0;
    e.rdata = '0; e.tag = 8;
    return e;
  endfunction

  task automatic cmp(input string what, input int tag, input logic [15:0] act,
                     input logic [15:0] expv);
    if (act !== expv) begin
      errors++;
      $display("FAIL R%0d %s actual %h expected %h at cycle %0d",
               tag, what, act, expv, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      exp_t e;
      cycles++;
      e = (q.size() != 0) ? q.pop_front() : idle_e();
      checks++;
      cmp("ce_n", e.tag, 16'(mem_ce_n), 16'(e.ce_n));
      cmp("oe_n", e.tag, 16'(mem_oe_n), 16'(e.oe_n));
      cmp("we_n", e.tag, 16'(mem_we_n), 16'(e.we_n));
      cmp("dq_oe", e.tag, 16'(mem_dq_oe), 16'(e.dq_oe));
      cmp("lane_n", 10, 16'(mem_lane_n), 16'(e.lane_n));        // R10
      cmp("req_ready", 8, 16'(req_ready), 16'(e.rdy));          // R8
      cmp("rsp_valid", e.chk_rd ? e.tag : 3, 16'(rsp_valid), 16'(e.rsp));
      if (!e.ce_n) cmp("mem_addr", 9, mem_addr, e.addr);        // R9
      if (e.chk_dq) cmp("mem_dq_o", e.tag, mem_dq_o, e.dq);
      if (e.chk_rd) cmp("rsp_rdata", e.tag, rsp_rdata, e.rdata);
      if (mem_dq_oe && !mem_oe_n) cmp("contention", 6, 16'h1, 16'h0); // R6
    end
  end

  function automatic logic [15:0] mexp(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  task automatic request(input bit wr, input logic [15:0] a,
                         input logic [15:0] d, input logic [1:0] m);
    exp_t e;
    int n = 0;
    logic [15:0] old;
    old = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    if (m == 2'b00) begin
      e = idle_e(); e.rsp = 1; e.chk_rd = 1; e.rdata = 16'h0; e.tag = 7; // R7
      q.push_back(e); n++;
    end else if (!wr) begin
      for (int i = 0; i < RDW; i++) begin                                // R2
        e = idle_e(); e.ce_n = 0; e.oe_n = 0; e.lane_n = ~m; e.rdy = 0;
        e.addr = a; e.tag = 2; q.push_back(e); n++;
      end
      e = idle_e(); e.rsp = 1; e.chk_rd = 1; e.rdata = old & mexp(m);   // R3
      e.tag = 3; q.push_back(e); n++;
    end else begin
      for (int i = 0; i < TA; i++) begin                                 // R4
        e = idle_e(); e.ce_n = 0; e.lane_n = ~m; e.rdy = 0; e.addr = a;
        e.tag = 4; q.push_back(e); n++;
      end
      for (int i = 0; i < WEL; i++) begin
        e = idle_e(); e.ce_n = 0; e.we_n = 0; e.lane_n = ~m; e.rdy = 0;
        e.dq_oe = 1; e.chk_dq = 1; e.dq = d; e.addr = a; e.tag = 4;
        q.push_back(e); n++;
      end
      e = idle_e(); e.dq_oe = 1; e.chk_dq = 1; e.dq = d; e.rdy = 0;     // R5
      e.tag = 5; q.push_back(e); n++;
      e = idle_e(); e.rsp = 1; e.tag = 5; q.push_back(e); n++;
      shadow[int'(a)] = (old & ~mexp(m)) | (d & mexp(m));
    end
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    while (q.size() != n) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic drain();
    while (q.size() != 0) begin @(negedge clk); #1; end
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;                                                            // R1
    if ({mem_ce_n, mem_oe_n, mem_we_n, mem_lane_n, mem_dq_oe, rsp_valid, req_ready}
        !== 8'b1111_1001) begin
      errors++;
      $display("FAIL R1 reset pins actual %b expected 11111001",
               {mem_ce_n, mem_oe_n, mem_we_n, mem_lane_n, mem_dq_oe, rsp_valid, req_ready});
    end
    @(negedge clk); rst_n = 1; #1;
    @(negedge clk); #1;

    request(1, 16'h0010, 16'hA55A, 2'b11); drain();
    request(0, 16'h0010, 16'h0000, 2'b11); drain();
    request(1, 16'h0010, 16'h1234, 2'b01); drain();   // R10 low lane only
    request(0, 16'h0010, 16'h0000, 2'b11); drain();
    request(1, 16'h0020, 16'hBEEF, 2'b10); drain();   // R10 high lane only
    request(0, 16'h0020, 16'h0000, 2'b10); drain();
    request(0, 16'h0020, 16'h0000, 2'b01); drain();
    request(1, 16'h0010, 16'hFFFF, 2'b00); drain();   // R7 write, no access
    request(0, 16'h0010, 16'h0000, 2'b00); drain();   // R7 read, no access
    request(0, 16'h0010, 16'h0000, 2'b11); drain();
    request(0, 16'h0010, 16'h0000, 2'b11);            // R8 held request below
    request(1, 16'h00FF, 16'hC3C3, 2'b11); drain();
    request(0, 16'h00FF, 16'h0000, 2'b11);
    request(1, 16'hFFFF, 16'h7E81, 2'b11); drain();   // R6 write right after read
    request(0, 16'hFFFF, 16'h0000, 2'b01); drain();
    request(0, 16'hFFFF, 16'h0000, 2'b11); drain();
    finish_run();
  end

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      finish_run();
    end
  end
endmodule